// File: doc/BRIEF.md
# Vectored Bus Interrupt Requester

This block raises a vectored interrupt on a backplane bus on behalf of a counting module. Three causes can request service: a counter overflow (level input), an external snapshot strobe (rising edge) and a test cause set and cleared by software. Each cause is latched into a pending bit only while its enable is set. The pending bits are ORed into an internal interrupt flag that software can poll without using the bus interrupt at all.

A configuration word holds a global bus interrupt enable, a 3-bit interrupt level and an 8-bit vector in its low twelve bits. A fixed module number and version fill the upper twenty bits, which read back constant. When the flag is set, the global enable is on and the level is not zero, the block drives a request on the programmed level. A bus acknowledge cycle whose level matches the programmed one gets the vector on the low data byte and releases the request. The request stays released until every pending bit has been cleared, which software does by disabling a source, removing its cause and enabling it again.

Top module: `virq_ctrl`

## Requirements
- R1: After a synchronous reset, the low configuration bits, all enables, the test cause, all pending bits, the request, the acknowledge hit and the vector output are zero.
- R2: The configuration read word is {module number 16'h3800, version 4'h1, low 12 bits}. Bits 11..0 read back the last written value: bit 11 is the global enable, bits 10..8 the level, bits 7..0 the vector. Writes to bits 31..12 have no effect.
- R3: On a control write, bit 20+k sets the enable of source k and bit 28+k clears it (k = 0 overflow, 1 snapshot, 2 test). Clear wins when both are written. Bit 1 sets the test cause and bit 9 clears it, clear winning. Enables change one cycle after the write.
- R4: Pending bit k is set at the clock edge where its enable is already set and its cause is seen. Overflow's cause is the input level, snapshot's is a rising edge of its input, test's is the test cause bit.
- R5: A pending bit stays set while its enable stays set, also after the cause has gone away. It clears at the first edge after its enable reads zero.
- R6: The internal interrupt flag is the OR of the three pending bits.
- R7: The request is high one cycle after the flag is high, provided the global enable is set and the level is nonzero. Otherwise it stays low.
- R8: An acknowledge whose level equals the programmed level while the request is high yields, in the next cycle, a hit strobe and the vector on the vector output. Any other acknowledge yields no hit and a zero vector.
- R9: After a matching acknowledge the request drops in the next cycle. It stays low until the flag has been low for at least one cycle; then a new pending cause raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_lvl | input | 1 | Counter overflow condition (level) |
| snap_in | input | 1 | External snapshot strobe (rising edge counts) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word set/clear bits |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| iack | input | 1 | Bus acknowledge cycle active |
| iack_lvl | input | 3 | Level being acknowledged |
| src_en | output | 3 | Per-source enables |
| src_pend | output | 3 | Per-source pending bits |
| irq_int | output | 1 | Internal interrupt flag for polling |
| irq_req | output | 1 | Bus interrupt request |
| irq_lvl | output | 3 | Level the request is placed on |
| iack_hit | output | 1 | Acknowledge matched in previous cycle |
| vec_out | output | 8 | Vector on the low data byte |

## Verification
The hardest state to reach from the ports is the re-arm path. An acknowledge releases the request, and it may come back only after every pending bit has been emptied for at least one cycle. The stimulus reaches it both by a directed sequence (acknowledge, disable, drop the cause, idle, re-enable) and by long random runs. Those runs keep the acknowledge level equal to the programmed level half the time and toggle enables sparsely, so pending bits both persist and drain. A per-cycle reference model checks every output across these runs.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int NSRC       = 3;
  localparam int SRC_OVF    = 0;
  localparam int SRC_SNAP   = 1;
  localparam int SRC_TEST   = 2;
  localparam int DATA_W     = 32;
  localparam int CTL_TST_ON = 1;
  localparam int CTL_TST_OFF= 9;
  localparam int CTL_EN_ON  = 20;
  localparam int CTL_EN_OFF = 28;
  localparam int LVL_W      = 3;
  localparam int VEC_W      = 8;
  localparam int CFG_RW_W   = VEC_W + LVL_W + 1;

  typedef struct packed {
    logic             gen;
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } cfg_t;
endpackage

// File: rtl/virq_ctl_bits.sv
module virq_ctl_bits #(
  parameter int N      = 3,
  parameter int W      = 32,
  parameter int EN_ON  = 20,
  parameter int EN_OFF = 28,
  parameter int T_ON   = 1,
  parameter int T_OFF  = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [N-1:0] en,
  output logic         test
);
  logic [N-1:0] on_b, off_b;
  assign on_b  = wdata[EN_ON  +: N];
  assign off_b = wdata[EN_OFF +: N];

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      test <= 1'b0;
    end else if (we) begin
      en   <= (en | on_b) & ~off_b;
      test <= (test | wdata[T_ON]) & ~wdata[T_OFF];
    end
  end
endmodule

// File: rtl/virq_src_latch.sv
module virq_src_latch #(
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cause,
  output logic pend
);
  logic seen;

  generate
    if (EDGE_MODE) begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= cause;
      end
      assign seen = cause & ~prev;
    end else begin : g_level
      assign seen = cause;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= en & (pend | seen);
  end
endmodule

// File: rtl/virq_cfg_reg.sv
module virq_cfg_reg #(
  parameter int          W       = 32,
  parameter int          RW_W    = 12,
  parameter int          ID_W    = 16,
  parameter int          VER_W   = 4,
  parameter logic [15:0] MOD_ID  = 16'h3800,
  parameter logic [3:0]  MOD_VER = 4'h1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [W-1:0]    wdata,
  output logic [RW_W-1:0] cfg,
  output logic [W-1:0]    rdata
);
  localparam logic [ID_W-1:0]  ID_C  = MOD_ID[ID_W-1:0];
  localparam logic [VER_W-1:0] VER_C = MOD_VER[VER_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= wdata[RW_W-1:0];
  end

  assign rdata = {ID_C, VER_C, cfg};
endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_flag,
  input  logic             gen_en,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VEC_W-1:0] vec,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_lvl,
  output logic             req,
  output logic             hit,
  output logic [VEC_W-1:0] vec_out
);
  logic served;
  logic match;

  assign match = iack & (iack_lvl == lvl) & req;

  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      served  <= 1'b0;
      hit     <= 1'b0;
      vec_out <= '0;
    end else begin
      req     <= int_flag & gen_en & (|lvl) & ~served & ~match;
      if (match)          served <= 1'b1;
      else if (!int_flag) served <= 1'b0;
      hit     <= match;
      vec_out <= match ? vec : '0;
    end
  end
endmodule

// File: rtl/virq_ctrl.sv
module virq_ctrl
  import virq_pkg::*;
#(
  parameter logic [15:0] MOD_ID  = 16'h3800,
  parameter logic [3:0]  MOD_VER = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_lvl,
  input  logic              snap_in,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              iack,
  input  logic [LVL_W-1:0]  iack_lvl,
  output logic [NSRC-1:0]   src_en,
  output logic [NSRC-1:0]   src_pend,
  output logic              irq_int,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_lvl,
  output logic              iack_hit,
  output logic [VEC_W-1:0]  vec_out
);
  logic                test_q;
  logic [CFG_RW_W-1:0] cfg_raw;
  cfg_t                cfg;
  logic [NSRC-1:0]     cause;

  virq_ctl_bits #(
    .N(NSRC), .W(DATA_W), .EN_ON(CTL_EN_ON), .EN_OFF(CTL_EN_OFF),
    .T_ON(CTL_TST_ON), .T_OFF(CTL_TST_OFF)
  ) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .en(src_en), .test(test_q)
  );

  virq_cfg_reg #(
    .W(DATA_W), .RW_W(CFG_RW_W), .ID_W(16), .VER_W(4),
    .MOD_ID(MOD_ID), .MOD_VER(MOD_VER)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg_raw), .rdata(cfg_rdata)
  );

  assign cfg = cfg_t'(cfg_raw);

  always_comb begin
    cause           = '0;
    cause[SRC_OVF]  = ovf_lvl;
    cause[SRC_SNAP] = snap_in;
    cause[SRC_TEST] = test_q;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      virq_src_latch #(.EDGE_MODE(i == SRC_SNAP)) u_lat (
        .clk(clk), .rst(rst), .en(src_en[i]), .cause(cause[i]),
        .pend(src_pend[i])
      );
    end
  endgenerate

  assign irq_int = |src_pend;
  assign irq_lvl = cfg.lvl;

  virq_ack_unit #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst(rst), .int_flag(irq_int), .gen_en(cfg.gen),
    .lvl(cfg.lvl), .vec(cfg.vec), .iack(iack), .iack_lvl(iack_lvl),
    .req(irq_req), .hit(iack_hit), .vec_out(vec_out)
  );
endmodule

// File: rtl/virq_ctrl_chk.sv
module virq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        iack,
  input logic [2:0]  iack_lvl,
  input logic [2:0]  src_en,
  input logic [2:0]  src_pend,
  input logic        irq_int,
  input logic        irq_req,
  input logic        iack_hit,
  input logic [7:0]  vec_out
);
  // R8
  ack_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (iack && iack_lvl == cfg_rdata[10:8] && irq_req)
    |=> (iack_hit && vec_out == $past(cfg_rdata[7:0])));

  // R8
  quiet_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !iack_hit |-> vec_out == 8'h00);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    iack_hit |-> !irq_req);

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(irq_int && cfg_rdata[11] && cfg_rdata[10:8] != 3'd0));

  // R5
  pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (src_pend & ~$past(src_en)) == 3'b000);
endmodule

bind virq_ctrl virq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .iack(iack),
  .iack_lvl(iack_lvl), .src_en(src_en), .src_pend(src_pend),
  .irq_int(irq_int), .irq_req(irq_req), .iack_hit(iack_hit),
  .vec_out(vec_out)
);

// File: tb/virq_ctrl_test.sv
module virq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, ovf_lvl, snap_in, ctl_we, cfg_we, iack;
  logic [31:0] ctl_wdata, cfg_wdata, cfg_rdata;
  logic [2:0]  iack_lvl, src_en, src_pend, irq_lvl;
  logic        irq_int, irq_req, iack_hit;
  logic [7:0]  vec_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [2:0]  m_en, m_pend;
  logic        m_test, m_snapq, m_req, m_done, m_hit;
  logic [11:0] m_cfg;
  logic [7:0]  m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  virq_ctrl uut (
    .clk(clk), .rst(rst), .ovf_lvl(ovf_lvl), .snap_in(snap_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .iack(iack),
    .iack_lvl(iack_lvl), .src_en(src_en), .src_pend(src_pend),
    .irq_int(irq_int), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .iack_hit(iack_hit), .vec_out(vec_out)
  );

  task automatic chk(input bit ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] c);
    return {16'h3800, 4'h1, c};
  endfunction

  task automatic model_step();
    logic [2:0] cause;
    logic       mint, match;
    if (rst) begin
      m_en = 0; m_pend = 0; m_test = 0; m_snapq = 0; m_req = 0;
      m_done = 0; m_hit = 0; m_cfg = 0; m_vec = 0;
      return;
    end
    cause = {m_test, snap_in & ~m_snapq, ovf_lvl};
    mint  = |m_pend;
    match = iack && iack_lvl == m_cfg[10:8] && m_req;
    m_pend  = m_en & (m_pend | cause);
    if (ctl_we) begin
      m_en   = (m_en | ctl_wdata[22:20]) & ~ctl_wdata[30:28];
      m_test = (m_test | ctl_wdata[1]) & ~ctl_wdata[9];
    end
    m_snapq = snap_in;
    m_req   = mint && m_cfg[11] && m_cfg[10:8] != 0 && !m_done && !match;
    m_done  = match ? 1'b1 : (mint ? m_done : 1'b0);
    m_hit   = match;
    m_vec   = match ? m_cfg[7:0] : 8'h00;
    if (cfg_we) m_cfg = cfg_wdata[11:0];
  endtask

  task automatic compare_all();
    chk(cfg_rdata == exp_rd(m_cfg), "R2 cfg_rdata", cfg_rdata, exp_rd(m_cfg));
    chk(src_en == m_en, "R3 src_en", 32'(src_en), 32'(m_en));
    chk(src_pend == m_pend, "R4 src_pend", 32'(src_pend), 32'(m_pend));
    chk(irq_int == |m_pend, "R6 irq_int", 32'(irq_int), 32'(|m_pend));
    chk(irq_req == m_req, "R7 irq_req", 32'(irq_req), 32'(m_req));
    chk(irq_lvl == m_cfg[10:8], "R7 irq_lvl", 32'(irq_lvl), 32'(m_cfg[10:8]));
    chk(iack_hit == m_hit, "R8 iack_hit", 32'(iack_hit), 32'(m_hit));
    chk(vec_out == m_vec, "R8 vec_out", 32'(vec_out), 32'(m_vec));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic ctl(input logic [31:0] d);
    ctl_we = 1; ctl_wdata = d; cyc(); ctl_we = 0; ctl_wdata = 0;
  endtask

  task automatic cfgw(input logic [31:0] d);
    cfg_we = 1; cfg_wdata = d; cyc(); cfg_we = 0; cfg_wdata = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst = 1; ovf_lvl = 0; snap_in = 0; ctl_we = 0; cfg_we = 0; iack = 0;
    ctl_wdata = 0; cfg_wdata = 0; iack_lvl = 0;
    repeat (3) cyc();
    rst = 0;
    // R1 reset state
    chk(cfg_rdata == 32'h3800_1000 && src_en == 0 && src_pend == 0 &&
        !irq_req && !iack_hit && vec_out == 0, "R1 reset", cfg_rdata, 32'h3800_1000);

    // R2 readback, upper bits read-only
    cfgw(32'h0000_0BA5);
    chk(cfg_rdata == 32'h3800_1BA5, "R2 write", cfg_rdata, 32'h3800_1BA5);
    cfgw(32'hFFFF_FBA5);
    chk(cfg_rdata == 32'h3800_1BA5, "R2 upper ignored", cfg_rdata, 32'h3800_1BA5);

    // overflow request and acknowledge
    ctl(32'h0010_0000);
    ovf_lvl = 1; cyc();
    chk(src_pend == 3'b001, "R4 overflow pend", 32'(src_pend), 32'h1);
    cyc();
    chk(irq_req == 1, "R7 request", 32'(irq_req), 32'h1);
    iack = 1; iack_lvl = 2; cyc();
    chk(!iack_hit && vec_out == 0, "R8 wrong level", 32'(vec_out), 32'h0);
    iack_lvl = 3; cyc();
    chk(iack_hit && vec_out == 8'hA5, "R8 vector", 32'(vec_out), 32'hA5);
    chk(!irq_req, "R9 release", 32'(irq_req), 32'h0);
    iack = 0;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(!irq_req, "R9 held low", 32'(irq_req), 32'h0);
    end
    // disable, remove cause, re-enable
    ovf_lvl = 0; ctl(32'h1000_0000); cyc();
    chk(src_pend[0] == 0, "R5 cleared by disable", 32'(src_pend), 32'h0);
    cyc();
    ovf_lvl = 1; ctl(32'h0010_0000); cyc(); cyc();
    chk(irq_req == 1, "R9 rearm", 32'(irq_req), 32'h1);

    // snapshot edge stays pending
    ovf_lvl = 0; ctl(32'h1020_0000);
    snap_in = 1; cyc(); snap_in = 0;
    repeat (5) cyc();
    chk(src_pend[1] == 1, "R5 snapshot sticky", 32'(src_pend), 32'h2);

    // set and clear together: clear wins
    ctl(32'h4040_0000);
    chk(src_en[2] == 0, "R3 clear wins", 32'(src_en), 32'(src_en & 3'b011));
    ctl(32'h0040_0002); cyc();
    chk(src_pend[2] == 1, "R4 test source", 32'(src_pend), 32'h4);

    // level zero and global disable block the request
    cfgw(32'h0000_0800); cyc();
    chk(!irq_req && irq_int, "R7 level zero", 32'(irq_req), 32'h0);
    cfgw(32'h0000_03A5); cyc();
    chk(!irq_req, "R7 global off", 32'(irq_req), 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      ovf_lvl   = ($urandom % 4) == 0;
      snap_in   = ($urandom % 3) == 0;
      ctl_we    = ($urandom % 8) == 0;
      ctl_wdata = ctl_we ? ($urandom & $urandom) : 32'h0;
      cfg_we    = ($urandom % 40) == 0;
      cfg_wdata = cfg_we ? ($urandom | 32'h800) : 32'h0;
      iack      = ($urandom % 5) == 0;
      iack_lvl  = ($urandom % 2) ? m_cfg[10:8] : 3'($urandom);
      cyc();
    end
    ctl_we = 0; cfg_we = 0; iack = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule